// File: doc/BRIEF.md
# Cascaded Match Priority Chain

This block settles which of several address-matching stages may drive a shared result bus. Each stage holds the outcome of its most recent compare: a hit flag, a multiple-entry flag and the matching entry address. The stages are wired as a daisy chain from highest priority (stage 0) to lowest. A stage passes a match indication down to the stage below it. A stage that matches may take the bus only when no stage above it matches.

A stage drives only while its own active-low output enable is low. A stage that is blocked by a higher match never drives, whatever its own output enable. One stage carries a configuration bit that marks it as the bottom of the chain. When no stage holds a match, that stage drives all ones, so that a miss is visible on the bus. The shared bus is modelled as an OR of per-stage values that are gated by each stage's drive enable. The value driven is the stage's page number concatenated with its held entry address.

Compare results are captured on the clock edge that samples the compare strobe. The results, and the match and multiple-match flags derived from them, stay unchanged until the next compare.

Top module: `match_chain`

## Requirements
- R1: After reset no stage holds a match, match_o and multi_o are 0, and no stage drives except the marked bottom stage when its output enable is low.
- R2: On a cycle with cmp_i high, a stage whose sel_i bit is high captures its local hit, its multiple-entry flag (taken only when hit) and its address. The result is visible from the next cycle.
- R3: The highest-priority stage holding a hit drives {page, address} on bus_o when its oe_ni bit is 0. Page is the stage index, in the top PAGE_W bits; the address is in the low ADDR_W bits.
- R4: A stage below a stage holding a hit never asserts its drive_en_o bit, whatever its oe_ni bit.
- R5: A stage whose oe_ni bit is 1 never drives. When no stage drives, bus_o is 0 and bus_valid_o is 0.
- R6: When no stage holds a hit, the stage whose last_cfg_i bit is 1 drives all ones if its oe_ni bit is 0. With no bit of last_cfg_i set, nothing drives on a miss.
- R7: At most one bit of drive_en_o is high in any cycle, and bus_valid_o is high exactly when one is high.
- R8: match_o is high when any stage holds a hit.
- R9: multi_o is high when two or more stages hold a hit, or when a stage holding a hit captured its multiple-entry flag.
- R10: Between compares, match_o, multi_o and the held addresses do not change, even when the local inputs change.
- R11: A stage whose sel_i bit is low during a compare clears any match it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Compare strobe; results are captured on this edge |
| sel_i | input | N_STAGES | Per-stage select during a compare |
| loc_hit_i | input | N_STAGES | Local match of each stage |
| loc_multi_i | input | N_STAGES | Stage has several matching entries |
| loc_addr_i | input | N_STAGES*ADDR_W | Local match address, stage k in bits [k*ADDR_W +: ADDR_W] |
| oe_ni | input | N_STAGES | Active-low output enable per stage |
| last_cfg_i | input | N_STAGES | Marks the bottom stage of the chain |
| drive_en_o | output | N_STAGES | Stage currently driving the bus |
| bus_o | output | PAGE_W+ADDR_W | Shared result bus |
| bus_valid_o | output | 1 | Some stage drives the bus |
| match_o | output | 1 | Any held match in the chain |
| multi_o | output | 1 | Multiple match in the chain |

## Verification
A corrupted held hit bit shows in the first cycle after the compare that wrote it. It appears as a wrong drive_en_o bit, a wrong page on bus_o, or a lost all-ones miss word. A broken chain link makes two drive enables rise together, or lets a lower stage drive over a higher one. Either fault is seen at once for any oe_ni pattern that leaves both stages enabled. A capture or clear fault in a stage survives only until the next compare, so every vector of the bench samples the cycle that directly follows its compare.

// File: rtl/match_chain_pkg.sv
package match_chain_pkg;
  typedef struct packed {
    logic hit;
    logic multi;
  } stage_res_t;
endpackage

// File: rtl/match_stage.sv
module match_stage
  import match_chain_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int PAGE_W  = 4,
  parameter int PAGE_ID = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmp_i,
  input  logic                     sel_i,
  input  logic                     loc_hit_i,
  input  logic                     loc_multi_i,
  input  logic [ADDR_W-1:0]        loc_addr_i,
  input  logic                     oe_ni,
  input  logic                     last_i,
  input  logic                     match_in_i,
  input  logic                     multi_in_i,
  output logic                     match_out_o,
  output logic                     multi_out_o,
  output logic                     drive_en_o,
  output logic [PAGE_W+ADDR_W-1:0] drive_val_o
);
  localparam int                W        = PAGE_W + ADDR_W;
  localparam logic [PAGE_W-1:0] PAGE_VAL = PAGE_W'(PAGE_ID);

  stage_res_t        res_q;
  logic [ADDR_W-1:0] addr_q;
  logic              win, miss_own;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      addr_q <= '0;
    end else if (cmp_i) begin
      if (sel_i) begin
        res_q.hit   <= loc_hit_i;
        res_q.multi <= loc_hit_i & loc_multi_i;
        addr_q      <= loc_addr_i;
      end else begin
        res_q <= '0; // deselected stage drops old result
      end
    end
  end

  always_comb begin
    match_out_o = match_in_i | res_q.hit;
    multi_out_o = multi_in_i | (res_q.hit & (match_in_i | res_q.multi));
    win         = res_q.hit & ~match_in_i;
    miss_own    = last_i & ~match_out_o;
    drive_en_o  = ~oe_ni & (win | miss_own);
    if (!drive_en_o)  drive_val_o = '0;
    else if (win)     drive_val_o = {PAGE_VAL, addr_q};
    else              drive_val_o = {W{1'b1}};
  end

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmp_i) && $past(sel_i) |-> res_q.hit == $past(loc_hit_i));

  p_unsel_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmp_i) && !$past(sel_i) |-> !res_q.hit && !res_q.multi);

  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmp_i) |-> $stable(addr_q));
endmodule

// File: rtl/match_bus_merge.sv
module match_bus_merge #(
  parameter int N_STAGES = 4,
  parameter int W        = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_STAGES-1:0]   drive_en_i,
  input  logic [N_STAGES*W-1:0] drive_val_i,
  output logic [W-1:0]          bus_o,
  output logic                  valid_o
);
  always_comb begin
    bus_o   = '0;
    valid_o = 1'b0;
    for (int k = 0; k < N_STAGES; k++) begin
      bus_o   = bus_o | drive_val_i[k*W +: W];
      valid_o = valid_o | drive_en_i[k];
    end
  end

  p_onehot_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drive_en_i));

  p_valid_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(drive_en_i) == 1);
endmodule

// File: rtl/match_chain.sv
module match_chain #(
  parameter int N_STAGES = 4,
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmp_i,
  input  logic [N_STAGES-1:0]          sel_i,
  input  logic [N_STAGES-1:0]          loc_hit_i,
  input  logic [N_STAGES-1:0]          loc_multi_i,
  input  logic [N_STAGES*ADDR_W-1:0]   loc_addr_i,
  input  logic [N_STAGES-1:0]          oe_ni,
  input  logic [N_STAGES-1:0]          last_cfg_i,
  output logic [N_STAGES-1:0]          drive_en_o,
  output logic [PAGE_W+ADDR_W-1:0]     bus_o,
  output logic                         bus_valid_o,
  output logic                         match_o,
  output logic                         multi_o
);
  localparam int W = PAGE_W + ADDR_W;

  logic [N_STAGES:0]     match_c, multi_c;
  logic [N_STAGES*W-1:0] drive_val;

  assign match_c[0] = 1'b0;
  assign multi_c[0] = 1'b0;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    match_stage #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_ID(k)) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmp_i       (cmp_i),
      .sel_i       (sel_i[k]),
      .loc_hit_i   (loc_hit_i[k]),
      .loc_multi_i (loc_multi_i[k]),
      .loc_addr_i  (loc_addr_i[k*ADDR_W +: ADDR_W]),
      .oe_ni       (oe_ni[k]),
      .last_i      (last_cfg_i[k]),
      .match_in_i  (match_c[k]),
      .multi_in_i  (multi_c[k]),
      .match_out_o (match_c[k+1]),
      .multi_out_o (multi_c[k+1]),
      .drive_en_o  (drive_en_o[k]),
      .drive_val_o (drive_val[k*W +: W])
    );

    p_oe_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_ni[k] |-> !drive_en_o[k]);

    if (k > 0) begin : g_lower
      p_lower_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_c[k] |-> !drive_en_o[k]);
    end
  end

  match_bus_merge #(.N_STAGES(N_STAGES), .W(W)) u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drive_en_i  (drive_en_o),
    .drive_val_i (drive_val),
    .bus_o       (bus_o),
    .valid_o     (bus_valid_o)
  );

  assign match_o = match_c[N_STAGES];
  assign multi_o = multi_c[N_STAGES];

  p_miss_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !match_o |-> bus_o == {W{1'b1}});

  p_flags_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmp_i) |-> $stable(match_o) && $stable(multi_o));

  p_multi_implies_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> match_o);
endmodule

// File: tb/match_chain_tb.sv
module match_chain_tb;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int PW = 4;
  localparam int W  = PW + AW;
  localparam int NV = 12;
  // {sel, hit, multi, oe_n}, bit k = stage k
  localparam logic [15:0] VEC [NV] = '{
    16'hF1_00, 16'hF6_00, 16'hF6_02, 16'hFC_00,
    16'hF8_80, 16'hF0_00, 16'hF0_08, 16'h5F_00,
    16'h0F_F0, 16'hFA_05, 16'hF4_4B, 16'hE1_10
  };

  logic clk = 1'b0, rst_n = 1'b0, cmp = 1'b0;
  logic [N-1:0] sel = '0, hit = '0, mul = '0, oe_n = '1, last = 4'b1000;
  logic [N*AW-1:0] addr = '0;
  logic [N-1:0] drv;
  logic [W-1:0] bus;
  logic valid, match, multi;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  match_chain #(.N_STAGES(N), .ADDR_W(AW), .PAGE_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .sel_i(sel), .loc_hit_i(hit),
    .loc_multi_i(mul), .loc_addr_i(addr), .oe_ni(oe_n), .last_cfg_i(last),
    .drive_en_o(drv), .bus_o(bus), .bus_valid_o(valid), .match_o(match),
    .multi_o(multi)
  );

  function automatic logic [AW-1:0] st_addr(int k, int salt);
    return AW'(k * 12'h300 + salt * 7 + 1);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic compare_with(logic [N-1:0] s, logic [N-1:0] h, logic [N-1:0] m, int salt);
    @(negedge clk);
    sel = s; hit = h; mul = m; cmp = 1'b1;
    for (int k = 0; k < N; k++) addr[k*AW +: AW] = st_addr(k, salt);
    @(negedge clk);
    cmp = 1'b0;
  endtask

  // expected outputs from held hits, multi flags, oe and last config
  task automatic expect_out(string tag, logic [N-1:0] held, logic [N-1:0] hmul,
                            logic [N-1:0] oen, logic [N-1:0] lst, int salt);
    logic [N-1:0] e_drv = '0;
    logic [W-1:0] e_bus = '0;
    int first = -1;
    for (int k = N - 1; k >= 0; k--) if (held[k]) first = k;
    if (first >= 0) begin
      if (!oen[first]) begin
        e_drv[first] = 1'b1;
        e_bus = {PW'(first), st_addr(first, salt)};
      end
    end else begin
      for (int k = 0; k < N; k++)
        if (lst[k] && !oen[k]) begin e_drv[k] = 1'b1; e_bus = '1; end
    end
    #1;
    chk(drv == e_drv, {tag, " R3 R4 drive_en"}, 32'(drv), 32'(e_drv));
    chk(bus == e_bus, {tag, " R3 R6 bus"}, 32'(bus), 32'(e_bus));
    chk(valid == (e_drv != '0), {tag, " R5 R7 valid"}, 32'(valid), 32'(e_drv != '0));
    chk(match == (held != '0), {tag, " R8 match"}, 32'(match), 32'(held != '0));
    chk(multi == (($countones(held) > 1) || ((held & hmul) != '0)), {tag, " R9 multi"},
        32'(multi), 32'(($countones(held) > 1) || ((held & hmul) != '0)));
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    oe_n = '0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, only bottom stage drives ones
    expect_out("R1 reset", '0, '0, '0, last, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [N-1:0] vs = VEC[i][15:12], vh = VEC[i][11:8];
      logic [N-1:0] vm = VEC[i][7:4], vo = VEC[i][3:0];
      @(negedge clk); oe_n = vo;
      compare_with(vs, vh, vm, i);
      expect_out($sformatf("R2 vec%0d", i), vs & vh, vs & vh & vm, vo, last, i);
    end

    // R10: inputs change without compare, results hold
    compare_with(4'hF, 4'b0110, 4'b0100, 20);
    oe_n = '0;
    @(negedge clk);
    sel = '0; hit = 4'b0001; mul = '1;
    for (int k = 0; k < N; k++) addr[k*AW +: AW] = st_addr(k, 33);
    repeat (3) @(negedge clk);
    expect_out("R10 hold", 4'b0110, 4'b0100, '0, last, 20);

    // R11: deselected stage clears an earlier hit
    compare_with(4'hF, 4'b0001, 4'b0000, 21);
    expect_out("R11 pre", 4'b0001, '0, '0, last, 21);
    compare_with(4'hE, 4'b0001, 4'b0000, 22);
    expect_out("R11 cleared", '0, '0, '0, last, 22);

    // R6: no bottom stage marked, miss drives nothing
    last = '0;
    expect_out("R6 no last", '0, '0, '0, '0, 22);
    last = 4'b1000;

    // R4: every oe low, stage1 wins over lower hitting stages
    compare_with(4'hF, 4'b1110, 4'b0000, 23);
    expect_out("R4 all oe", 4'b1110, '0, '0, last, 23);
    oe_n = 4'b0010;
    expect_out("R4 R5 top blocked", 4'b1110, '0, 4'b0010, last, 23);

    finish_run();
  end
endmodule